// File: doc/BRIEF.md
# Direct Power Control Vector Selector

This block picks the switching state of a three-leg, two-level inverter once per control sample. It takes the signed active and reactive power errors (reference minus measured; in disturbance-rejection operation both references are zero, so the errors are the negated disturbances), two programmable hysteresis half-widths, and the alpha-beta components of the grid voltage. It returns the three leg gate bits.

Each power error feeds its own two-level hysteresis comparator with memory. The voltage vector is placed in one of twelve 30-degree sectors by sign tests and two slope comparisons, with no arctangent. The two comparator bits and the sector index address a 48-entry constant table of voltage vectors, and the chosen vector is registered into the gate outputs when the sample strobe is high.

Top module: `dpc_vector_sel`

## Requirements
- R1: On a strobe, an active-power comparator whose error is at or above +band_p goes to 1; this test has priority, so with a zero band and a zero error the result is 1.
- R2: On a strobe, an active-power comparator whose error is at or below -band_p (and not at or above +band_p) goes to 0.
- R3: When an error lies strictly inside its band on a strobe, its comparator keeps its previous value; both comparators reset to 0.
- R4: The reactive comparator uses err_q and band_q with the same rules as R1 to R3 and keeps its own memory, independent of the active one.
- R5: The voltage angle theta = atan2(v_beta, v_alpha) selects sector n (1..12) with (n-2)*30 deg <= theta < (n-1)*30 deg, angles wrapped into that range.
- R6: The selected vector is table[n][dp,dq] with, per sector n listed as (dp,dq) = 00/01/10/11: 1: v6 v1 v6 v7; 2: v1 v2 v7 v7; 3: v1 v2 v1 v0; 4: v2 v3 v0 v0; 5: v2 v3 v2 v7; 6: v3 v4 v7 v7; 7: v3 v4 v3 v0; 8: v4 v5 v0 v0; 9: v4 v5 v4 v7; 10: v5 v6 v7 v7; 11: v5 v6 v5 v0; 12: v6 v1 v0 v0. The table uses the comparator values produced by the same strobe.
- R7: gate_abc = {Sa,Sb,Sc} with bit 2 = leg a: v0=000, v1=100, v2=110, v3=010, v4=011, v5=001, v6=101, v7=111.
- R8: gate_abc is registered: it changes only on the clock edge where strobe is high and shows that sample's vector one clock after it; reset drives it to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Sample strobe; comparators and gates update when high |
| err_p | input | EW | Signed active power error |
| err_q | input | EW | Signed reactive power error |
| band_p | input | EW-1 | Active hysteresis half-width, unsigned |
| band_q | input | EW-1 | Reactive hysteresis half-width, unsigned |
| v_alpha | input | VW | Signed alpha voltage component |
| v_beta | input | VW | Signed beta voltage component |
| gate_abc | output | 3 | Leg gate bits {Sa,Sb,Sc} |

## Verification
The comparator memory is never visible at the ports. It shows only through the table, and for some sectors two comparator states give the same vector. The stimulus therefore first pushes an error outside its band, then holds it inside the band while the voltage angle is moved to a sector where the held bit changes the vector. The same pattern is run with only one error inside its band to separate the two memories. Exact band-edge errors and a zero band test the priority of the set condition. The angles stay at least two degrees away from sector edges, so fixed-point rounding of the slope constants cannot make the result ambiguous.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int NSECT = 12;
  localparam int NENT  = NSECT * 4;

  // Vector number (0..7) for sector n (1..12) and comparator bits.
  function automatic int sel_vector(input int n, input bit dp, input bit dq);
    int k;
    int v;
    k = n / 2;
    case ({dp, dq})
      2'b00: v = (k == 0) ? 6 : k;
      2'b01: v = (k + 1 == 7) ? 1 : k + 1;
      2'b10: begin
        if (n % 2 == 1) v = ((n - 1) / 2 == 0) ? 6 : (n - 1) / 2;
        else            v = (k % 2 == 1) ? 7 : 0;
      end
      default: v = (((n - 1) / 2) % 2 == 0) ? 7 : 0;
    endcase
    return v;
  endfunction

  // Leg pattern {a,b,c} of vector v.
  function automatic logic [2:0] vec_to_gates(input int v);
    logic [2:0] g;
    case (v)
      1:       g = 3'b100;
      2:       g = 3'b110;
      3:       g = 3'b010;
      4:       g = 3'b011;
      5:       g = 3'b001;
      6:       g = 3'b101;
      7:       g = 3'b111;
      default: g = 3'b000;
    endcase
    return g;
  endfunction

  // Content of ROM entry i: i = {sector_index[3:0], dp, dq}.
  function automatic logic [2:0] rom_entry(input int i);
    return vec_to_gates(sel_vector((i >> 2) + 1, i[1], i[0]));
  endfunction

endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int EW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [EW-1:0] err,
  input  logic        [EW-2:0] band,
  output logic                 q_next,
  output logic                 q
);
  logic signed [EW:0] e_x;
  logic signed [EW:0] b_x;

  assign e_x = {err[EW-1], err};
  assign b_x = {2'b00, band};

  always_comb begin
    if (e_x >= b_x)       q_next = 1'b1;
    else if (e_x <= -b_x) q_next = 1'b0;
    else                  q_next = q;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= q_next;
  end
endmodule

// File: rtl/sector_map.sv
module sector_map #(
  parameter int VW   = 16,
  parameter int FRAC = 16
) (
  input  logic signed [VW-1:0] v_alpha,
  input  logic signed [VW-1:0] v_beta,
  output logic        [3:0]    sect_idx
);
  localparam int PRW = VW + FRAC + 3;
  localparam real SCALE = 2.0 ** FRAC;
  localparam int unsigned T30 = $rtoi(0.5773502692 * SCALE);
  localparam int unsigned T60 = $rtoi(1.7320508076 * SCALE);

  logic [VW:0]    mag_a, mag_b;
  logic [PRW-1:0] lhs, lim30, lim60;
  logic [1:0]     reg3;
  logic [3:0]     slice;
  logic           neg_a, neg_b;

  assign neg_a = v_alpha[VW-1];
  assign neg_b = v_beta[VW-1];
  assign mag_a = neg_a ? -{v_alpha[VW-1], v_alpha} : {v_alpha[VW-1], v_alpha};
  assign mag_b = neg_b ? -{v_beta[VW-1], v_beta}   : {v_beta[VW-1], v_beta};

  assign lhs   = PRW'(mag_b) << FRAC;
  assign lim30 = PRW'(mag_a) * PRW'(T30);
  assign lim60 = PRW'(mag_a) * PRW'(T60);

  always_comb begin
    if (lhs < lim30)      reg3 = 2'd0;
    else if (lhs < lim60) reg3 = 2'd1;
    else                  reg3 = 2'd2;
  end

  // 30-degree slice 0..11 measured from the alpha axis.
  always_comb begin
    case ({neg_a, neg_b})
      2'b00:   slice = 4'(reg3);
      2'b10:   slice = 4'd5 - 4'(reg3);
      2'b11:   slice = 4'd6 + 4'(reg3);
      default: slice = 4'd11 - 4'(reg3);
    endcase
    sect_idx = (slice == 4'd11) ? 4'd0 : slice + 4'd1;
  end
endmodule

// File: rtl/vector_rom.sv
module vector_rom #(
  parameter int DEPTH = dpc_pkg::NENT,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  output logic [2:0]    data
);
  logic [2:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign rom[i] = dpc_pkg::rom_entry(i);
  end

  assign data = (int'(addr) < DEPTH) ? rom[addr] : 3'b000;
endmodule

// File: rtl/dpc_vector_sel.sv
module dpc_vector_sel #(
  parameter int EW   = 16,
  parameter int VW   = 16,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic signed [EW-1:0] err_p,
  input  logic signed [EW-1:0] err_q,
  input  logic        [EW-2:0] band_p,
  input  logic        [EW-2:0] band_q,
  input  logic signed [VW-1:0] v_alpha,
  input  logic signed [VW-1:0] v_beta,
  output logic        [2:0]    gate_abc
);
  localparam int AW = $clog2(dpc_pkg::NENT);

  logic [1:0] cmp_next;
  logic [1:0] cmp_q;
  logic [3:0] sect_idx;
  logic [2:0] vec_bits;
  logic signed [EW-1:0] errs [2];
  logic        [EW-2:0] bands [2];

  assign errs[0]  = err_q;
  assign errs[1]  = err_p;
  assign bands[0] = band_q;
  assign bands[1] = band_p;

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    hyst_cmp #(.EW(EW)) u_cmp (
      .clk    (clk),
      .rst    (rst),
      .en     (strobe),
      .err    (errs[c]),
      .band   (bands[c]),
      .q_next (cmp_next[c]),
      .q      (cmp_q[c])
    );
  end

  sector_map #(.VW(VW), .FRAC(FRAC)) u_sect (
    .v_alpha  (v_alpha),
    .v_beta   (v_beta),
    .sect_idx (sect_idx)
  );

  vector_rom #(.DEPTH(dpc_pkg::NENT), .AW(AW)) u_rom (
    .addr ({sect_idx, cmp_next}),
    .data (vec_bits)
  );

  always_ff @(posedge clk) begin
    if (rst)         gate_abc <= 3'b000;
    else if (strobe) gate_abc <= vec_bits;
  end

  logic unused_ok;
  assign unused_ok = ^cmp_q;
endmodule

// File: rtl/dpc_vector_sel_chk.sv
module dpc_vector_sel_chk #(
  parameter int EW = 16,
  parameter int VW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 strobe,
  input logic signed [EW-1:0] err_p,
  input logic signed [EW-1:0] err_q,
  input logic        [EW-2:0] band_p,
  input logic        [EW-2:0] band_q,
  input logic signed [VW-1:0] v_alpha,
  input logic signed [VW-1:0] v_beta,
  input logic        [2:0]    gate_abc
);
  int ep, eq, hp, hq, va, vb;
  always_comb begin
    ep = int'(err_p);
    eq = int'(err_q);
    hp = int'(band_p);
    hq = int'(band_q);
    va = int'(v_alpha);
    vb = int'(v_beta);
  end

  p_reset_zero_r8: assert property (@(posedge clk)
    rst |=> (gate_abc == 3'b000));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(gate_abc));

  // Both comparators set: every sector maps to a zero vector (R6).
  p_zero_vec_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && ep >= hp && eq >= hq) |=> (gate_abc == 3'b000 || gate_abc == 3'b111));

  // Active comparator cleared: never a zero vector (R6).
  p_active_vec_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && ep <= -hp && ep < hp) |=> (gate_abc != 3'b000 && gate_abc != 3'b111));

  // Shallow first-quadrant angle lies in sector 2; both cleared gives v1 (R5).
  p_sector2_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe && va > 0 && vb > 0 && 4 * vb < va && ep <= -hp && ep < hp
     && eq <= -hq && eq < hq) |=> (gate_abc == 3'b100));
endmodule

bind dpc_vector_sel dpc_vector_sel_chk #(.EW(EW), .VW(VW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .strobe   (strobe),
  .err_p    (err_p),
  .err_q    (err_q),
  .band_p   (band_p),
  .band_q   (band_q),
  .v_alpha  (v_alpha),
  .v_beta   (v_beta),
  .gate_abc (gate_abc)
);

// File: tb/sim_dpc_vector_sel.sv
module sim_dpc_vector_sel;
  localparam int EW = 16;
  localparam int VW = 16;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic signed [EW-1:0] err_p = '0, err_q = '0;
  logic        [EW-2:0] band_p = '0, band_q = '0;
  logic signed [VW-1:0] v_alpha = '0, v_beta = '0;
  logic        [2:0]    gate_abc;

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit done = 0;
  string cur_req = "R8";

  // Reference: vectors per sector, index {dp,dq}.
  int tbl [12][4] = '{'{6,1,6,7}, '{1,2,7,7}, '{1,2,1,0}, '{2,3,0,0},
                      '{2,3,2,7}, '{3,4,7,7}, '{3,4,3,0}, '{4,5,0,0},
                      '{4,5,4,7}, '{5,6,7,7}, '{5,6,5,0}, '{6,1,0,0}};
  int enc [8] = '{0, 4, 6, 2, 3, 1, 5, 7};

  int m_dp = 0, m_dq = 0, m_gates = 0;

  always #2 clk = ~clk;

  dpc_vector_sel #(.EW(EW), .VW(VW)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe),
    .err_p(err_p), .err_q(err_q), .band_p(band_p), .band_q(band_q),
    .v_alpha(v_alpha), .v_beta(v_beta), .gate_abc(gate_abc)
  );

  function automatic int ref_sector(int va, int vb);
    real th;
    int n;
    th = $atan2(real'(vb), real'(va)) * 180.0 / PI;
    if (th < 0.0) th = th + 360.0;
    n = int'($floor(th / 30.0)) + 2;
    if (n > 12) n = n - 12;
    return n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dp = 0; m_dq = 0; m_gates = 0;
    end else if (strobe) begin
      if (int'(err_p) >= int'(band_p)) m_dp = 1;
      else if (int'(err_p) <= -int'(band_p)) m_dp = 0;
      if (int'(err_q) >= int'(band_q)) m_dq = 1;
      else if (int'(err_q) <= -int'(band_q)) m_dq = 0;
      m_gates = enc[tbl[ref_sector(int'(v_alpha), int'(v_beta)) - 1][m_dp * 2 + m_dq]];
    end
  end

  always @(posedge clk) begin
    #1;
    if (checking) begin
      checks++;
      if (int'(gate_abc) != m_gates) begin
        errors++;
        $display("FAIL %s gate_abc actual %b expected %b", cur_req, gate_abc, 3'(m_gates));
      end
    end
  end

  task automatic drive(input int ep, input int eq, input int hp, input int hq,
                       input real deg, input bit stb, input string r);
    @(negedge clk);
    err_p   = EW'(ep);
    err_q   = EW'(eq);
    band_p  = (EW-1)'(hp);
    band_q  = (EW-1)'(hq);
    v_alpha = VW'($rtoi(20000.0 * $cos(deg * PI / 180.0)));
    v_beta  = VW'($rtoi(20000.0 * $sin(deg * PI / 180.0)));
    strobe  = stb;
    cur_req = r;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (gate_abc !== 3'b000) begin
      errors++;
      $display("FAIL R8 reset gate_abc actual %b expected 000", gate_abc);
    end
    checking = 1;

    // R5 R6 R7: every sector and comparator combination, away from edges.
    for (int s = 0; s < 12; s++) begin
      for (int c = 0; c < 4; c++) begin
        drive((c >= 2) ? 3000 : -3000, c[0] ? 3000 : -3000, 1000, 1000,
              30.0 * s + 15.0, 1'b1, "R6");
        drive((c >= 2) ? 3000 : -3000, c[0] ? 3000 : -3000, 1000, 1000,
              30.0 * s + 3.0, 1'b1, "R5");
        drive((c >= 2) ? 3000 : -3000, c[0] ? 3000 : -3000, 1000, 1000,
              30.0 * s + 27.0, 1'b1, "R7");
      end
    end

    // R1 R2: exact band edges and zero band.
    drive(1000, -1000, 1000, 1000, 15.0, 1'b1, "R1");
    drive(-1000, -1000, 1000, 1000, 15.0, 1'b1, "R2");
    drive(0, 0, 0, 0, 75.0, 1'b1, "R1");
    drive(-1, -1, 0, 0, 75.0, 1'b1, "R2");

    // R3: set dp, then hold inside band while sector moves (sector 2 -> dp visible).
    drive(2000, -2000, 500, 500, 15.0, 1'b1, "R3");
    drive(100, -100, 500, 500, 15.0, 1'b1, "R3");
    drive(-499, 499, 500, 500, 135.0, 1'b1, "R3");
    drive(-2000, 2000, 500, 500, 15.0, 1'b1, "R3");
    drive(499, -499, 500, 500, 15.0, 1'b1, "R3");

    // R4: only the reactive error inside its band, active error toggles.
    drive(2000, 2000, 500, 500, 45.0, 1'b1, "R4");
    drive(-2000, 10, 500, 500, 45.0, 1'b1, "R4");
    drive(2000, -10, 500, 500, 45.0, 1'b1, "R4");
    drive(-2000, -2000, 500, 500, 45.0, 1'b1, "R4");
    drive(2000, 300, 500, 500, 105.0, 1'b1, "R4");

    // R8: strobe low with changing inputs; output must not move.
    for (int i = 0; i < 6; i++)
      drive((i % 2) ? 4000 : -4000, (i % 3) ? 4000 : -4000, 100, 100,
            30.0 * i + 10.0, 1'b0, "R8");
    drive(4000, -4000, 100, 100, 200.0, 1'b1, "R8");
    drive(-4000, 4000, 100, 100, 300.0, 1'b0, "R8");

    // Mixed random traffic.
    for (int i = 0; i < 3000; i++) begin
      int hp, hq;
      hp = $urandom_range(0, 800);
      hq = $urandom_range(0, 800);
      drive($urandom_range(0, 4000) - 2000, $urandom_range(0, 4000) - 2000, hp, hq,
            30.0 * $urandom_range(0, 11) + 2.0 + real'($urandom_range(0, 26)),
            ($urandom_range(0, 3) != 0), "R3");
    end

    drive(0, 0, 0, 0, 15.0, 1'b0, "R8");
    @(posedge clk); #1;
    checking = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule